// File: doc/BRIEF.md
# Code-Programmed Bit-Slice ALU

This block is an N-bit arithmetic and logic unit whose operation is set entirely by three 4-bit truth-table codes instead of an opcode. Every bit position is an identical slice. In each slice, two programmable two-input function units read the operand bits and produce a propagate bit and a kill bit. A third function unit reads the propagate bit and the incoming carry and produces the result bit. A fixed ripple chain passes a carry from each slice to the next.

The block is purely combinational and holds no state. A controller selects an operation by driving the three codes and the carry input. One code set gives bitwise logic. Others give addition, increment, or subtraction with borrow. The carry output reports the carry or borrow that leaves the most significant slice.

Top module: `tt_bitslice_alu`

## Requirements
- R1: Each function unit outputs bit `code[2*x + y]` of its 4-bit code, where x is its first input (operand A bit, or the propagate bit) and y is its second input (operand B bit, or the incoming carry). With R=12, P codes 6, 9 and 1 give A xor B, A xnor B and A nor B.
- R2: With P=8 and R=12, the result is A & B.
- R3: With P=14 and R=12, the result is A | B.
- R4: With P=12 and R=12, the result equals A for every value of B.
- R5: With P=6, K=1 and R=6, the 9-bit value {carry_out, result} equals A + B + carry_in.
- R6: With P=12, K=3, R=6 and carry_in=1, the 9-bit value {carry_out, result} equals A + 1, and B has no effect.
- R7: With P=9, K=4 and R=9, carry_in acts as the incoming borrow and the result is A - B - carry_in modulo 2^N. With carry_in=0 this equals A + ~B + 1.
- R8: Under the R7 codes, carry_out is the borrow out: it is 1 exactly when A < B + carry_in.
- R9: With R=12, the result does not depend on the K code or on carry_in.
- R10: An R code of 0 forces the result to all zeros, and an R code of 15 forces it to all ones, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| prop_fn | input | 4 | Truth-table code of the propagate unit |
| kill_fn | input | 4 | Truth-table code of the kill unit |
| out_fn | input | 4 | Truth-table code of the result unit |
| carry_in | input | 1 | Carry or borrow into the least significant slice |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry or borrow out of the most significant slice |

## Verification
The bound checker tests whenever its inputs change, so it covers every code set it recognises: AND, OR, add, increment, subtract with its borrow output, and the constant result codes. Each is compared against plain arithmetic on the ports. Other behaviour can only be shown by the bench's scenarios. This covers the code-bit index convention for XOR, XNOR and NOR, the independence of logic results from the K code and the carry input, and the carry wrap-around at the all-ones boundary.

// File: rtl/tt_bitslice_alu.sv
module tt_bitslice_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       prop_fn,
  input  logic [3:0]       kill_fn,
  input  logic [3:0]       out_fn,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] kill;
  logic [WIDTH:0]   chain;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign prop[i]   = prop_fn[{opa[i], opb[i]}];
    assign kill[i]   = kill_fn[{opa[i], opb[i]}];
    assign result[i] = out_fn[{prop[i], chain[i]}];
  end

  // ripple: propagate passes the carry, otherwise a non-kill generates one
  always_comb begin
    chain[0] = carry_in;
    for (int i = 0; i < WIDTH; i++)
      chain[i+1] = prop[i] ? chain[i] : ~kill[i];
  end

  assign carry_out = chain[WIDTH];
endmodule

module tt_bitslice_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       prop_fn,
  input logic [3:0]       kill_fn,
  input logic [3:0]       out_fn,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH:0] sum_ref;
  logic [WIDTH:0] inc_ref;
  logic [WIDTH:0] sub_rhs;

  assign sum_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
  assign inc_ref = {1'b0, opa} + 1'b1;
  assign sub_rhs = {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (prop_fn == 4'd8 && out_fn == 4'd12)
      a_r2_and: assert (result == (opa & opb)) else $error("R2 AND mismatch");
    if (prop_fn == 4'd14 && out_fn == 4'd12)
      a_r3_or: assert (result == (opa | opb)) else $error("R3 OR mismatch");
    if (prop_fn == 4'd6 && kill_fn == 4'd1 && out_fn == 4'd6)
      a_r5_add: assert ({carry_out, result} == sum_ref) else $error("R5 add mismatch");
    if (prop_fn == 4'd12 && kill_fn == 4'd3 && out_fn == 4'd6 && carry_in)
      a_r6_inc: assert ({carry_out, result} == inc_ref) else $error("R6 increment mismatch");
    if (prop_fn == 4'd9 && kill_fn == 4'd4 && out_fn == 4'd9) begin
      a_r7_sub: assert (result == WIDTH'(opa - opb - {{(WIDTH-1){1'b0}}, carry_in}))
        else $error("R7 difference mismatch");
      a_r8_borrow: assert (carry_out == ({1'b0, opa} < sub_rhs))
        else $error("R8 borrow mismatch");
    end
    if (out_fn == 4'd0)
      a_r10_zero: assert (result == '0) else $error("R10 zero code mismatch");
    if (out_fn == 4'd15)
      a_r10_ones: assert (result == '1) else $error("R10 ones code mismatch");
  end
endmodule

bind tt_bitslice_alu tt_bitslice_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/tt_bitslice_alu_tb_top.sv
module tt_bitslice_alu_tb_top;
  localparam int W = 8;
  // entry: a, b, P, K, R, cin, expected result, expected carry, carry checked
  localparam int VW = 2*W + 13 + W + 2;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'hF0, 8'h3C, 4'd8,  4'd0, 4'd12, 1'b0, 8'h30, 1'b0, 1'b0},  // R2
    {8'h55, 8'hA0, 4'd14, 4'd0, 4'd12, 1'b1, 8'hF5, 1'b0, 1'b0},  // R3
    {8'hA5, 8'h3C, 4'd12, 4'd0, 4'd12, 1'b0, 8'hA5, 1'b0, 1'b0},  // R4
    {8'h7F, 8'h01, 4'd6,  4'd1, 4'd6,  1'b0, 8'h80, 1'b0, 1'b1},  // R5
    {8'hFF, 8'h00, 4'd6,  4'd1, 4'd6,  1'b1, 8'h00, 1'b1, 1'b1},  // R5
    {8'hFF, 8'h5A, 4'd12, 4'd3, 4'd6,  1'b1, 8'h00, 1'b1, 1'b1},  // R6
    {8'h05, 8'h07, 4'd9,  4'd4, 4'd9,  1'b0, 8'hFE, 1'b1, 1'b1},  // R7 R8
    {8'h10, 8'h0F, 4'd9,  4'd4, 4'd9,  1'b1, 8'h00, 1'b0, 1'b1},  // R7 R8
    {8'h3C, 8'h0F, 4'd6,  4'd0, 4'd12, 1'b0, 8'h33, 1'b0, 1'b0},  // R1 xor
    {8'h3C, 8'h0F, 4'd1,  4'd0, 4'd12, 1'b0, 8'hC0, 1'b0, 1'b0}   // R1 nor
  };

  logic clk = 1'b0;
  logic [W-1:0] opa, opb, result;
  logic [3:0] prop_fn, kill_fn, out_fn;
  logic carry_in, carry_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tt_bitslice_alu #(.WIDTH(W)) dut_i (.*);

  function automatic string tag_of(input logic [3:0] p, input logic [3:0] k, input logic [3:0] r);
    if (r == 4'd12 && p == 4'd8) return "R2";
    if (r == 4'd12 && p == 4'd14) return "R3";
    if (r == 4'd12 && p == 4'd12) return "R4";
    if (r == 4'd6 && p == 4'd6 && k == 4'd1) return "R5";
    if (r == 4'd6 && p == 4'd12) return "R6";
    if (r == 4'd9) return "R7/R8";
    return "R1";
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] p,
                       input logic [3:0] k, input logic [3:0] r, input logic c);
    @(posedge clk);
    opa = a; opb = b; prop_fn = p; kill_fn = k; out_fn = r; carry_in = c;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h P=%0d K=%0d R=%0d cin=%b)",
               tag, got, exp, opa, opb, prop_fn, kill_fn, out_fn, carry_in);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W:0] ref9;
    opa = '0; opb = '0; prop_fn = '0; kill_fn = '0; out_fn = '0; carry_in = 1'b0;
    // idle state: all codes zero, R10 zero code
    @(negedge clk);
    check("R10", {1'b0, result}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1 -: W], v[VW-W-1 -: W], v[W+14 -: 4], v[W+10 -: 4], v[W+6 -: 4], v[W+2]);
      check(tag_of(prop_fn, kill_fn, out_fn), {1'b0, result}, {1'b0, v[W+1 -: W]});
      if (v[0]) check(tag_of(prop_fn, kill_fn, out_fn), {W'(0), carry_out}, {W'(0), v[1]});
    end

    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] a, b, ra, rb;
      logic c;
      a = W'($urandom); b = W'($urandom); c = 1'($urandom);
      ra = W'($urandom); rb = 4'($urandom);
      drive(a, b, 4'd8, 4'd0, 4'd12, 1'b0);
      check("R2", {1'b0, result}, {1'b0, a & b});
      // R9: other K code and carry leave the logic result unchanged
      drive(a, b, 4'd8, rb[3:0], 4'd12, ~c);
      check("R9", {1'b0, result}, {1'b0, a & b});
      drive(a, b, 4'd14, rb[3:0], 4'd12, c);
      check("R3", {1'b0, result}, {1'b0, a | b});
      drive(a, ra, 4'd12, 4'd0, 4'd12, c);
      check("R4", {1'b0, result}, {1'b0, a});
      drive(a, b, 4'd6, 4'd1, 4'd6, c);
      ref9 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      check("R5", {carry_out, result}, ref9);
      drive(a, ra, 4'd12, 4'd3, 4'd6, 1'b1);
      check("R6", {carry_out, result}, {1'b0, a} + 1'b1);
      drive(a, b, 4'd9, 4'd4, 4'd9, 1'b0);
      check("R7", {1'b0, result}, {1'b0, W'(a + ~b + 1'b1)});
      check("R8", {W'(0), carry_out}, {W'(0), a < b});
      drive(a, b, 4'd9, 4'd4, 4'd9, 1'b1);
      check("R7", {1'b0, result}, {1'b0, W'(a - b - 1'b1)});
      check("R8", {W'(0), carry_out}, {W'(0), {1'b0, a} < ({1'b0, b} + 1'b1)});
      drive(a, b, 4'd9, 4'd0, 4'd12, c);
      check("R1", {1'b0, result}, {1'b0, ~(a ^ b)});
      drive(a, b, 4'd5, rb[3:0], 4'd15, c);
      check("R10", {1'b0, result}, {1'b0, {W{1'b1}}});
      drive(a, b, 4'd6, 4'd1, 4'd0, c);
      check("R10", {1'b0, result}, '0);
    end

    // R5 boundary: all-ones plus all-ones plus carry
    drive('1, '1, 4'd6, 4'd1, 4'd6, 1'b1);
    check("R5", {carry_out, result}, {1'b1, {W{1'b1}}});
    // R8 boundary: equal operands, no borrow unless borrow in
    drive(8'h80, 8'h80, 4'd9, 4'd4, 4'd9, 1'b0);
    check("R8", {carry_out, result}, '0);
    drive(8'h00, 8'h00, 4'd9, 4'd4, 4'd9, 1'b1);
    check("R8", {carry_out, result}, {1'b1, {W{1'b1}}});
    finish_run();
  end
endmodule